// File: doc/BRIEF.md
# Prescaled Match Timer with Register Bus

This peripheral counts prescaled clock ticks with a 16-bit up-counter and raises an interrupt when the count reaches a programmable reload value. Software reaches it through a small register bus: a write strobe, a read strobe, a byte address, a write word and a read word. The counter shares the bus clock. A power-of-two prescaler sets the tick rate to the clock rate divided by 2^n, with n from 0 to 7.

A start command either fires once or repeats. The one-shot command halts the counter at zero after the first match. The repeating command restarts the count from zero after every match. Each match sets a sticky status flag. The interrupt line is high while that flag and its enable bit are both set. Software lowers the flag through a separate clear register.

Two registers are locked according to the enable state. The interrupt-enable register accepts writes only while the timer is off. The reload register accepts writes only while the timer is on. A driver therefore programs the interrupt enable first, turns the timer on, loads the reload value, and then issues the start command.

Top module: `lp_event_timer`

## Requirements
- R1: The control register is at offset 0x10, with enable at bit 0, one-shot start at bit 1 and repeating start at bit 2. A start bit takes effect only when bit 0 is also set in the same write. If both start bits are set, the repeating start wins. Start bits are not stored, so a control read returns only the enable bit.
- R2: The interrupt-enable register is at offset 0x08, with the match enable at bit 1. A write to it is accepted only while the timer is disabled and is ignored while the timer is enabled.
- R3: The reload register is at offset 0x18 and resets to 0xFFFF. A write to it is accepted only while the timer is enabled and is ignored while the timer is disabled.
- R4: The configuration register is at offset 0x0C, with the prescaler exponent n in bits 11:9. While the counter runs, it advances by one every 2^n clocks.
- R5: A match occurs on a tick at which the counter equals the reload value. A match sets the status flag, which reads at bit 1 of offset 0x00. `irq` is high while the flag and the match enable are both set.
- R6: Writing a 1 to bit 1 of the clear register at offset 0x04 clears the status flag. Writing zeros there leaves the flag unchanged.
- R7: In repeating mode the counter goes to 0 on a match and keeps counting. In one-shot mode it goes to 0 on the first match and stops.
- R8: A control write with bit 0 clear disables the timer, stops counting, and sets the counter and the prescaler phase to 0. The flag keeps its value.
- R9: A reload write of zero is ignored, so the reload value is never below 1.
- R10: A read presents the addressed register on `rdata` in the clock after the read strobe. The counter reads at offset 0x1C, and `cnt_o` shows the counter at all times.
- R11: After reset the timer is disabled, the counter, flag, match enable and prescaler are 0, the reload value is 0xFFFF, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (5) | Byte address of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, registered |
| irq | output | 1 | Match interrupt |
| cnt_o | output | CNT_W (16) | Current counter value |

## Verification
The assertions check on every cycle the rules that each clock edge must obey. The interrupt enable never changes while the timer is on. The reload value never changes while it is off and is never zero. A disabled timer holds a zero count. The counter only steps by one or returns to zero. Every match sets the flag, an accepted clear lowers it, and a one-shot match stops the run.

Only the bench scenarios can show properties that depend on a sequence of events:
- the exact cycle on which a prescaled count reaches each value
- that a repeating run comes back after a wrap
- that a start without enable does nothing
- that the locked registers and the clear register read back what the rules predict

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   localparam int unsigned OFF_STAT = 32'h00;
   localparam int unsigned OFF_CLR  = 32'h04;
   localparam int unsigned OFF_IEN  = 32'h08;
   localparam int unsigned OFF_CFG  = 32'h0C;
   localparam int unsigned OFF_CTRL = 32'h10;
   localparam int unsigned OFF_ARR  = 32'h18;
   localparam int unsigned OFF_CNT  = 32'h1C;

   localparam int unsigned B_EN     = 0;
   localparam int unsigned B_ONE    = 1;
   localparam int unsigned B_REP    = 2;
   localparam int unsigned B_MATCH  = 1;
   localparam int unsigned PSC_LSB  = 9;

   typedef struct packed {
      logic stop;
      logic go_single;
      logic go_cont;
   } cmd_t;
endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
   parameter int unsigned PSC_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             run,
   input  logic [PSC_W-1:0] psc,
   output logic             tick
);
   localparam int unsigned PH_W = (PSC_W == 0) ? 1 : ((1 << PSC_W) - 1);

   generate
      if (PSC_W == 0) begin : g_direct
         logic unused_in;
         assign unused_in = clr ^ clk ^ rst;
         assign tick = run;
      end else begin : g_divided
         logic [PH_W-1:0] phase_q;
         logic [PH_W-1:0] limit;

         assign limit = (PH_W'(1) << psc) - PH_W'(1);
         assign tick  = run && (phase_q >= limit);

         always_ff @(posedge clk) begin
            if (rst || clr) begin
               phase_q <= '0;
            end else if (run) begin
               phase_q <= tick ? '0 : phase_q + PH_W'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter
   import lpt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  cmd_t             cmd,
   input  logic             tick,
   input  logic [CNT_W-1:0] arr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             run_q,
   output logic             cont_q,
   output logic             match
);
   logic hit;

   assign hit   = (cnt_q == arr);
   assign match = run_q && tick && hit;

   always_ff @(posedge clk) begin
      if (rst || cmd.stop) begin
         cnt_q <= '0;
      end else if (run_q && tick) begin
         cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst || cmd.stop) begin
         run_q  <= 1'b0;
         cont_q <= 1'b0;
      end else if (cmd.go_cont || cmd.go_single) begin
         run_q  <= 1'b1;
         cont_q <= cmd.go_cont;
      end else if (match && !cont_q) begin
         run_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 3,
   parameter bit          RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              match,
   input  logic [CNT_W-1:0]  cnt,
   output logic              en_q,
   output logic              ie_q,
   output logic              flag_q,
   output logic [CNT_W-1:0]  arr_q,
   output logic [PSC_W-1:0]  psc_q,
   output cmd_t              cmd
);
   localparam logic [CNT_W-1:0] ARR_RST = '1;

   logic wr_stat_clr, wr_ien, wr_cfg, wr_ctrl, wr_arr;
   logic [CNT_W-1:0]  arr_new;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_wbits;

   assign unused_wbits = ^wdata;

   assign wr_stat_clr = wr_en && (addr == ADDR_W'(OFF_CLR));
   assign wr_ien      = wr_en && (addr == ADDR_W'(OFF_IEN));
   assign wr_cfg      = wr_en && (addr == ADDR_W'(OFF_CFG));
   assign wr_ctrl     = wr_en && (addr == ADDR_W'(OFF_CTRL));
   assign wr_arr      = wr_en && (addr == ADDR_W'(OFF_ARR));
   assign arr_new     = wdata[CNT_W-1:0];

   always_comb begin
      cmd.stop      = wr_ctrl && !wdata[B_EN];
      cmd.go_cont   = wr_ctrl &&  wdata[B_EN] && wdata[B_REP];
      cmd.go_single = wr_ctrl &&  wdata[B_EN] && wdata[B_ONE] && !wdata[B_REP];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q   <= 1'b0;
         ie_q   <= 1'b0;
         psc_q  <= '0;
         arr_q  <= ARR_RST;
      end else begin
         if (wr_ctrl)                          en_q  <= wdata[B_EN];
         if (wr_ien && !en_q)                  ie_q  <= wdata[B_MATCH];
         if (wr_cfg)                           psc_q <= wdata[PSC_LSB +: PSC_W];
         if (wr_arr && en_q && arr_new != '0)  arr_q <= arr_new;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= 1'b0;
      end else if (match) begin
         flag_q <= 1'b1;
      end else if (wr_stat_clr && wdata[B_MATCH]) begin
         flag_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (addr)
         ADDR_W'(OFF_STAT): rd_mux[B_MATCH] = flag_q;
         ADDR_W'(OFF_IEN):  rd_mux[B_MATCH] = ie_q;
         ADDR_W'(OFF_CFG):  rd_mux[PSC_LSB +: PSC_W] = psc_q;
         ADDR_W'(OFF_CTRL): rd_mux[B_EN] = en_q;
         ADDR_W'(OFF_ARR):  rd_mux[CNT_W-1:0] = arr_q;
         ADDR_W'(OFF_CNT):  rd_mux[CNT_W-1:0] = cnt;
         default:           rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (rst)        rdata <= '0;
            else if (rd_en) rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         logic unused_rd;
         assign unused_rd = rd_en;
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/lp_event_timer.sv
module lp_event_timer
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic [CNT_W-1:0]  cnt_o
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("lp_event_timer: CNT_W must lie in 2..DATA_W");
      end
      if (PSC_LSB + PSC_W > DATA_W) begin : g_bad_psc
         $error("lp_event_timer: prescaler field exceeds DATA_W");
      end
      if ((1 << ADDR_W) <= OFF_CNT) begin : g_bad_addr
         $error("lp_event_timer: ADDR_W too narrow for register map");
      end
   endgenerate

   cmd_t             cmd;
   logic             en_q, ie_q, flag_q;
   logic [CNT_W-1:0] arr_q, cnt_q;
   logic [PSC_W-1:0] psc_q;
   logic             run_q, cont_q, match, tick;

   lpt_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .PSC_W  (PSC_W),
      .RD_REG (1'b1)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .match  (match),
      .cnt    (cnt_q),
      .en_q   (en_q),
      .ie_q   (ie_q),
      .flag_q (flag_q),
      .arr_q  (arr_q),
      .psc_q  (psc_q),
      .cmd    (cmd)
   );

   lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk  (clk),
      .rst  (rst),
      .clr  (cmd.stop),
      .run  (run_q),
      .psc  (psc_q),
      .tick (tick)
   );

   lpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .cmd    (cmd),
      .tick   (tick),
      .arr    (arr_q),
      .cnt_q  (cnt_q),
      .run_q  (run_q),
      .cont_q (cont_q),
      .match  (match)
   );

   assign irq   = flag_q && ie_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/lp_event_timer_chk.sv
module lp_event_timer_chk
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              en_q,
   input logic              ie_q,
   input logic              flag_q,
   input logic [CNT_W-1:0]  arr_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              run_q,
   input logic              cont_q,
   input logic              match,
   input cmd_t              cmd
);
   p_ier_locked_r2: assert property (@(posedge clk) disable iff (rst)
      en_q |=> $stable(ie_q));

   p_arr_locked_r3: assert property (@(posedge clk) disable iff (rst)
      !en_q |=> $stable(arr_q));

   p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == '0));

   p_match_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
      match |=> flag_q);

   p_clear_drops_flag_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(OFF_CLR) && wdata[B_MATCH] && !match) |=> !flag_q);

   p_single_halts_r7: assert property (@(posedge clk) disable iff (rst)
      (match && !cont_q && !cmd.go_single && !cmd.go_cont && !cmd.stop) |=> !run_q);

   p_cont_wraps_r7: assert property (@(posedge clk) disable iff (rst)
      (match && cont_q && !cmd.stop) |=> (run_q && cnt_q == '0));

   p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
      !en_q |-> (cnt_q == '0 && !run_q));

   p_arr_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
      arr_q != '0);
endmodule

bind lp_event_timer lp_event_timer_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .en_q   (en_q),
   .ie_q   (ie_q),
   .flag_q (flag_q),
   .arr_q  (arr_q),
   .cnt_q  (cnt_q),
   .run_q  (run_q),
   .cont_q (cont_q),
   .match  (match),
   .cmd    (cmd)
);

// File: tb/lp_event_timer_test.sv
`timescale 1ns/100ps
module lp_event_timer_test;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 16;

   localparam logic [ADDR_W-1:0] A_STAT = 5'h00, A_CLR = 5'h04, A_IEN = 5'h08,
                                 A_CFG = 5'h0C, A_CTRL = 5'h10, A_ARR = 5'h18,
                                 A_CNT = 5'h1C;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              irq;
   logic [CNT_W-1:0]  cnt_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic rd_seen = 1'b0;

   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];

   always #2.5 clk = ~clk;

   lp_event_timer uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .cnt_o(cnt_o)
   );

   task automatic chk(input string tag, input logic [DATA_W-1:0] got,
                      input logic [DATA_W-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   // driver side of the scoreboard: queue the expected word, then issue the read
   task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                     input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_edges(input int k);
      repeat (k) @(posedge clk);
      @(negedge clk);
   endtask

   always @(posedge clk) rd_seen <= rd_en;

   // monitor side: one read result is due on each negedge after a strobe
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            n_run++; n_fail++;
            $display("FAIL R10: unexpected read data %0h expected none", rdata);
         end else begin
            chk(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 reset state
      chk("R11 cnt", DATA_W'(cnt_o), 0);
      chk("R11 irq", DATA_W'(irq), 0);
      rd(A_ARR,  32'hFFFF, "R11 arr reset");
      rd(A_STAT, 0, "R11 status");
      rd(A_IEN,  0, "R11 ien");
      rd(A_CFG,  0, "R11 cfg");
      rd(A_CTRL, 0, "R11 ctrl");

      // R3 reload locked while disabled; R2 enable accepted while disabled
      wr(A_ARR, 5);
      rd(A_ARR, 32'hFFFF, "R3 arr ignored when off");
      wr(A_IEN, 2);
      rd(A_IEN, 2, "R2 ien written when off");

      // R1 start without enable does nothing
      wr(A_CTRL, 32'h6);
      wait_edges(4);
      chk("R1 no start without enable", DATA_W'(cnt_o), 0);
      rd(A_CTRL, 0, "R1 ctrl still off");

      wr(A_CTRL, 1);
      wr(A_ARR, 5);
      rd(A_ARR, 5, "R3 arr written when on");
      wr(A_ARR, 0);
      rd(A_ARR, 5, "R9 zero reload ignored");
      wr(A_IEN, 0);
      rd(A_IEN, 2, "R2 ien ignored when on");
      wait_edges(2);
      chk("R1 enable alone does not count", DATA_W'(cnt_o), 0);

      // R7 repeating mode, reload 5, prescaler 0
      wr(A_CTRL, 5);
      wait_edges(3);
      chk("R7 cont count 3", DATA_W'(cnt_o), 3);
      chk("R5 no irq before match", DATA_W'(irq), 0);
      wait_edges(3);
      chk("R7 cont wrap to 0", DATA_W'(cnt_o), 0);
      chk("R5 irq at match", DATA_W'(irq), 1);
      wait_edges(3);
      chk("R7 cont keeps running", DATA_W'(cnt_o), 3);
      rd(A_CTRL, 1, "R1 start bits read zero");

      // R8 disable
      wr(A_CTRL, 0);
      chk("R8 cnt cleared", DATA_W'(cnt_o), 0);
      wait_edges(3);
      chk("R8 stays stopped", DATA_W'(cnt_o), 0);
      chk("R8 flag kept", DATA_W'(irq), 1);

      // R6 clear register
      wr(A_CLR, 0);
      rd(A_STAT, 2, "R6 zero write keeps flag");
      wr(A_CLR, 2);
      rd(A_STAT, 0, "R6 clear drops flag");
      chk("R6 irq low", DATA_W'(irq), 0);

      // R7 one-shot
      wr(A_CTRL, 1);
      wr(A_CTRL, 3);
      wait_edges(5);
      chk("R7 single count 5", DATA_W'(cnt_o), 5);
      chk("R5 irq low before single match", DATA_W'(irq), 0);
      wait_edges(1);
      chk("R7 single back to 0", DATA_W'(cnt_o), 0);
      chk("R5 irq at single match", DATA_W'(irq), 1);
      wait_edges(4);
      chk("R7 single stopped", DATA_W'(cnt_o), 0);
      rd(A_STAT, 2, "R5 status flag bit");
      rd(A_CNT, 0, "R10 counter read");

      // R4 prescaler n=2, reload 3
      wr(A_CTRL, 0);
      wr(A_CLR, 2);
      wr(A_CFG, 32'h400);
      rd(A_CFG, 32'h400, "R4 cfg readback");
      wr(A_CTRL, 1);
      wr(A_ARR, 3);
      wr(A_CTRL, 5);
      wait_edges(7);
      chk("R4 prescaled count at 7", DATA_W'(cnt_o), 1);
      wait_edges(1);
      chk("R4 prescaled count at 8", DATA_W'(cnt_o), 2);
      wait_edges(7);
      chk("R4 prescaled count at 15", DATA_W'(cnt_o), 3);
      chk("R5 no irq before prescaled match", DATA_W'(irq), 0);
      wait_edges(1);
      chk("R4 prescaled wrap at 16", DATA_W'(cnt_o), 0);
      chk("R5 irq at prescaled match", DATA_W'(irq), 1);
      wait_edges(5);
      rd(A_CNT, 1, "R10 running counter read");

      wr(A_CTRL, 0);
      wait_edges(2);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule